// File: doc/BRIEF.md
# Per-Line Video CRC Checker with Frame Error Threshold

This block sits on the receive side of a video stream. During every active line it folds one chosen byte lane of the pixel bus into a 32-bit CRC. In the horizontal blanking that follows, it collects the checksum and the frame number that the sender placed there, and compares the two checksums. It then writes the verdict back into the stream at a fixed blanking word and also holds it on status outputs. Everything on the bus and the three timing signals leaves the block one clock later, so the inserted verdict stays aligned with the words around it.

Within each frame, the block counts the lines whose CRC did not match. When that count reaches a programmable limit, it raises a frame error flag that stays set until the next frame begins. It also watches the frame numbers of successive frames and flags a number that does not follow on from the previous one.

Top module: `line_crc_checker`

## Requirements
- R1: The computed CRC uses generator 0x20044009, start value 0xFFFFFFFF, no input or output reflection and no final XOR, with each byte taken MSB first. It covers every active (DE high) byte of a line and restarts at the first active cycle of each line. The string "123456789" gives 0x4FD94EA8.
- R2: `byte_sel` = k selects bus bits [8k+7:8k] as the lane. The lane is used for the CRC and also for reading the CRC bytes and the frame number out of blanking.
- R3: Blanking word n is the n-th DE-low cycle after an active line, counting from 0. Words 0 to 3 carry the received CRC, most significant byte first. Word 4 carries the frame number. The comparison is made only when word 3 arrives, and `last_crc_o` then holds the 32-bit value received.
- R4: Outputs `pix_o`, `de_o`, `hs_o` and `vs_o` are the inputs delayed by one clock. The one exception is blanking word 3 of a line: in that word, bit 10 carries the mismatch result and bits 1:0 are driven to 0.
- R5: `line_err_o` holds the result of the most recent line (1 = mismatch). It changes only at the clock that follows blanking word 3.
- R6: The count of mismatching lines and `frame_err_o` both clear on every rising edge of `vs_i`.
- R7: When a mismatch brings the per-frame count up to a nonzero `err_thresh`, `frame_err_o` goes to 1. It stays at 1 until the next rising edge of `vs_i`. The count saturates at its maximum.
- R8: An `err_thresh` of 0 never sets `frame_err_o`.
- R9: The frame number in word 4 of the first line after a `vs_i` rising edge is loaded into `last_fid_o`. The same word on later lines of that frame is ignored.
- R10: `fid_jump_o` is updated at each frame-number capture. It is 1 when the new number is not the previous number plus one (modulo 256), and it is always 0 at the first capture after reset.
- R11: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| de_i | input | 1 | Data enable, high on active pixels |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync; its rising edge starts a frame |
| pix_i | input | PIX_W | Incoming pixel bus |
| byte_sel | input | SEL_W | Index of the byte lane that is checked |
| err_thresh | input | THR_W | Error lines per frame that raise the frame flag; 0 disables it |
| pix_o | output | PIX_W | Delayed pixel bus carrying the inserted status word |
| de_o | output | 1 | Delayed data enable |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |
| line_err_o | output | 1 | CRC result of the last line |
| frame_err_o | output | 1 | Sticky per-frame threshold flag |
| fid_jump_o | output | 1 | Frame number discontinuity |
| last_crc_o | output | 32 | CRC received on the last line |
| last_fid_o | output | 8 | Frame number last captured |

## Verification
The bench sends a one-pixel line, which exposes a design that seeds the CRC one cycle late or leaves out the first byte: such a design would report a good line as bad. Lines follow one another back to back, and a frame keeps producing bad lines after its threshold is reached. This catches a counter that does not restart on the sync edge, a flag that clears itself, and a flag that fires one line too early or too late. A zero threshold, a skipped frame number and a byte-lane change partway through the run are also covered. A design that ignored the select, or compared frame numbers without the modulo step, would show the wrong status. Each cycle the status word is compared bit by bit, so a verdict in the wrong blanking word, or reserved bits left as they arrived, shows up at once.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    localparam logic [31:0] CRC_POLY = 32'h2004_4009;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    localparam int OFF_W = 3;
    localparam logic [OFF_W-1:0] OFF_LAST_CRC = 3'd3;
    localparam logic [OFF_W-1:0] OFF_FID      = 3'd4;
    localparam logic [OFF_W-1:0] OFF_SAT      = '1;

    localparam int STATUS_BIT = 10;

    typedef struct packed {
        logic        valid;
        logic        bad;
        logic [31:0] rx_crc;
    } line_result_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] id;
    } fid_word_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/lcc_crc_acc.sv
module lcc_crc_acc
    import lcc_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int NB    = PIX_W / 8,
    parameter int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de,
    input  logic [PIX_W-1:0] pix,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       lane,
    output logic [31:0]      crc
);

    logic [7:0] slices [NB];
    logic       de_q;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign slices[g] = pix[8*g +: 8];
    end

    always_comb begin
        lane = '0;
        for (int k = 0; k < NB; k++) begin
            if (int'(sel) == k) lane = slices[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q <= 1'b0;
            crc  <= CRC_SEED;
        end else begin
            de_q <= de;
            if (de) crc <= crc_step(de_q ? crc : CRC_SEED, lane);
        end
    end

endmodule

// File: rtl/lcc_blank_rx.sv
module lcc_blank_rx
    import lcc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         de,
    input  logic [7:0]   lane,
    input  logic [31:0]  crc_calc,
    output line_result_t res,
    output fid_word_t    fid
);

    logic [OFF_W-1:0] off;
    logic             in_line;
    logic [23:0]      head;

    always_ff @(posedge clk) begin
        if (rst) begin
            off     <= OFF_SAT;
            in_line <= 1'b0;
            head    <= '0;
        end else if (de) begin
            off     <= '0;
            in_line <= 1'b1;
        end else begin
            if (off != OFF_SAT) off <= off + 1'b1;
            if (in_line && off < OFF_LAST_CRC) head <= {head[15:0], lane};
            if (in_line && off == OFF_FID) in_line <= 1'b0;
        end
    end

    always_comb begin
        res.valid  = !de && in_line && (off == OFF_LAST_CRC);
        res.rx_crc = {head, lane};
        res.bad    = res.valid && (res.rx_crc != crc_calc);
        fid.valid  = !de && in_line && (off == OFF_FID);
        fid.id     = lane;
    end

endmodule

// File: rtl/lcc_frame_track.sv
module lcc_frame_track
    import lcc_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vs,
    input  line_result_t     res,
    input  fid_word_t        fid,
    input  logic [THR_W-1:0] thresh,
    output logic             frame_err,
    output logic             fid_jump,
    output logic [7:0]       last_fid
);

    logic             vs_q;
    logic             new_frame;
    logic [THR_W-1:0] cnt;
    logic [THR_W-1:0] cnt_base;
    logic [THR_W:0]   cnt_inc;
    logic             want_fid;
    logic             have_fid;

    assign new_frame = vs && !vs_q;
    assign cnt_base  = new_frame ? '0 : cnt;
    assign cnt_inc   = {1'b0, cnt_base} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q      <= 1'b0;
            cnt       <= '0;
            frame_err <= 1'b0;
            want_fid  <= 1'b0;
            have_fid  <= 1'b0;
            fid_jump  <= 1'b0;
            last_fid  <= '0;
        end else begin
            vs_q <= vs;
            if (new_frame) begin
                cnt       <= '0;
                frame_err <= 1'b0;
                want_fid  <= 1'b1;
            end
            if (res.bad) begin
                if (!cnt_inc[THR_W]) cnt <= cnt_inc[THR_W-1:0];
                else                 cnt <= cnt_base;
                if (thresh != '0 && cnt_inc >= {1'b0, thresh}) frame_err <= 1'b1;
            end
            if (fid.valid && want_fid) begin
                last_fid <= fid.id;
                have_fid <= 1'b1;
                want_fid <= 1'b0;
                fid_jump <= have_fid && (fid.id != last_fid + 8'd1);
            end
        end
    end

endmodule

// File: rtl/line_crc_checker.sv
module line_crc_checker
    import lcc_pkg::*;
#(
    parameter  int PIX_W = 24,
    parameter  int THR_W = 8,
    localparam int NB    = PIX_W / 8,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_i,
    input  logic             hs_i,
    input  logic             vs_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic [SEL_W-1:0] byte_sel,
    input  logic [THR_W-1:0] err_thresh,
    output logic [PIX_W-1:0] pix_o,
    output logic             de_o,
    output logic             hs_o,
    output logic             vs_o,
    output logic             line_err_o,
    output logic             frame_err_o,
    output logic             fid_jump_o,
    output logic [31:0]      last_crc_o,
    output logic [7:0]       last_fid_o
);

    logic [7:0]       lane;
    logic [31:0]      crc_calc;
    line_result_t     res;
    fid_word_t        fid;
    logic [PIX_W-1:0] pix_mod;

    lcc_crc_acc #(.PIX_W(PIX_W), .NB(NB), .SEL_W(SEL_W)) u_crc (
        .clk(clk), .rst(rst), .de(de_i), .pix(pix_i), .sel(byte_sel),
        .lane(lane), .crc(crc_calc)
    );

    lcc_blank_rx u_blank (
        .clk(clk), .rst(rst), .de(de_i), .lane(lane), .crc_calc(crc_calc),
        .res(res), .fid(fid)
    );

    lcc_frame_track #(.THR_W(THR_W)) u_track (
        .clk(clk), .rst(rst), .vs(vs_i), .res(res), .fid(fid), .thresh(err_thresh),
        .frame_err(frame_err_o), .fid_jump(fid_jump_o), .last_fid(last_fid_o)
    );

    always_comb begin
        pix_mod = pix_i;
        if (res.valid) begin
            pix_mod[STATUS_BIT] = res.bad;
            pix_mod[1:0]        = 2'b00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o      <= '0;
            de_o       <= 1'b0;
            hs_o       <= 1'b0;
            vs_o       <= 1'b0;
            line_err_o <= 1'b0;
            last_crc_o <= '0;
        end else begin
            pix_o <= pix_mod;
            de_o  <= de_i;
            hs_o  <= hs_i;
            vs_o  <= vs_i;
            if (res.valid) begin
                line_err_o <= res.bad;
                last_crc_o <= res.rx_crc;
            end
        end
    end

endmodule

// File: rtl/lcc_sva.sv
module lcc_sva #(
    parameter int PIX_W = 24,
    parameter int THR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             de_i,
    input logic             hs_i,
    input logic             vs_i,
    input logic [PIX_W-1:0] pix_i,
    input logic [THR_W-1:0] err_thresh,
    input logic [PIX_W-1:0] pix_o,
    input logic             de_o,
    input logic             hs_o,
    input logic             vs_o,
    input logic             line_err_o,
    input logic             frame_err_o,
    input logic             fid_jump_o,
    input logic [7:0]       last_fid_o
);

    p_sync_delay_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (de_o == $past(de_i)) && (hs_o == $past(hs_i)) && (vs_o == $past(vs_i)));

    p_active_passthru_r4: assert property (@(posedge clk) disable iff (rst)
        de_i |=> pix_o == $past(pix_i));

    p_line_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        de_i |=> $stable(line_err_o));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_err_o && !$rose(vs_i)) |=> frame_err_o);

    p_zero_thresh_r8: assert property (@(posedge clk) disable iff (rst)
        (err_thresh == '0) |=> !$rose(frame_err_o));

    p_fid_hold_r9: assert property (@(posedge clk) disable iff (rst)
        de_i |=> $stable(last_fid_o) && $stable(fid_jump_o));

endmodule

bind line_crc_checker lcc_sva #(.PIX_W(PIX_W), .THR_W(THR_W)) u_lcc_sva (
    .clk(clk), .rst(rst), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i), .pix_i(pix_i),
    .err_thresh(err_thresh), .pix_o(pix_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o),
    .line_err_o(line_err_o), .frame_err_o(frame_err_o), .fid_jump_o(fid_jump_o),
    .last_fid_o(last_fid_o)
);

// File: tb/test_line_crc_checker.sv
module test_line_crc_checker;

    localparam int PIX_W = 24;
    localparam int THR_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             de_i, hs_i, vs_i;
    logic [PIX_W-1:0] pix_i;
    logic [1:0]       byte_sel;
    logic [THR_W-1:0] err_thresh;
    logic [PIX_W-1:0] pix_o;
    logic             de_o, hs_o, vs_o, line_err_o, frame_err_o, fid_jump_o;
    logic [31:0]      last_crc_o;
    logic [7:0]       last_fid_o;

    always #10 clk = ~clk;

    line_crc_checker #(.PIX_W(PIX_W), .THR_W(THR_W)) i_line_crc_checker (
        .clk(clk), .rst(rst), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i), .pix_i(pix_i),
        .byte_sel(byte_sel), .err_thresh(err_thresh), .pix_o(pix_o), .de_o(de_o),
        .hs_o(hs_o), .vs_o(vs_o), .line_err_o(line_err_o), .frame_err_o(frame_err_o),
        .fid_jump_o(fid_jump_o), .last_crc_o(last_crc_o), .last_fid_o(last_fid_o)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference model state
    logic [PIX_W-1:0] m_pix;
    logic m_de, m_hs, m_vs, m_lerr, m_ferr, m_jump;
    logic [31:0] m_lcrc;
    logic [7:0]  m_fid;
    bit   p_de, p_vs, pend, fid_pend, have_fid;
    int   off, cnt;
    logic [31:0] rx;
    byte unsigned lq[$];

    function automatic logic [31:0] ref_crc(byte unsigned q[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (q[i]) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[31] ^ q[i][b];
                c = c << 1;
                if (fb) c = c ^ 32'h2004_4009;
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] lane_of(logic [PIX_W-1:0] p, int s);
        return 8'((p >> (8 * s)) & 'hFF);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [7:0] b;
        int cur;
        b = lane_of(pix_i, int'(byte_sel));
        if (rst) begin
            m_pix = '0; m_de = 0; m_hs = 0; m_vs = 0; m_lerr = 0; m_ferr = 0; m_jump = 0;
            m_lcrc = '0; m_fid = '0; p_de = 0; p_vs = 0; pend = 0; fid_pend = 0;
            have_fid = 0; off = 7; cnt = 0; rx = '0; lq.delete();
            return;
        end
        m_pix = pix_i; m_de = de_i; m_hs = hs_i; m_vs = vs_i;
        if (vs_i && !p_vs) begin
            cnt = 0; m_ferr = 0; fid_pend = 1;
        end
        if (de_i) begin
            if (!p_de) lq.delete();
            lq.push_back(b);
            pend = 1;
            off = 0;
        end else begin
            cur = off;
            if (pend) begin
                if (cur < 3) rx = (rx << 8) | 32'(b);
                if (cur == 3) begin
                    logic [31:0] full;
                    logic mis;
                    full = (rx << 8) | 32'(b);
                    mis = (full != ref_crc(lq));
                    m_pix[10] = mis;
                    m_pix[1:0] = 2'b00;
                    m_lerr = mis;
                    m_lcrc = full;
                    if (mis) begin
                        if (cnt < 255) cnt++;
                        if (err_thresh != 0 && cnt >= int'(err_thresh)) m_ferr = 1;
                    end
                end
                if (cur == 4) begin
                    if (fid_pend) begin
                        m_jump = have_fid && (b != 8'(m_fid + 1));
                        m_fid = b;
                        have_fid = 1;
                        fid_pend = 0;
                    end
                    pend = 0;
                end
            end
            if (off < 7) off++;
        end
        p_de = de_i;
        p_vs = vs_i;
    endtask

    task automatic cyc(logic de, logic hs, logic vs, logic [PIX_W-1:0] p);
        de_i = de; hs_i = hs; vs_i = vs; pix_i = p;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R4 pix_o", 32'(pix_o), 32'(m_pix));
        check("R4 syncs", {29'd0, de_o, hs_o, vs_o}, {29'd0, m_de, m_hs, m_vs});
        check("R5 line_err", 32'(line_err_o), 32'(m_lerr));
        check("R3 last_crc", last_crc_o, m_lcrc);
        check("R7 frame_err", 32'(frame_err_o), 32'(m_ferr));
        check("R10 fid_jump", 32'(fid_jump_o), 32'(m_jump));
        check("R9 last_fid", 32'(last_fid_o), 32'(m_fid));
    endtask

    task automatic put_lane(inout logic [PIX_W-1:0] p, input logic [7:0] v);
        int s = int'(byte_sel);
        p = (p & ~(24'hFF << (8 * s))) | (PIX_W'(v) << (8 * s));
    endtask

    task automatic send_q(byte unsigned q[$], bit good, logic [7:0] fid);
        logic [PIX_W-1:0] p;
        logic [31:0] c;
        foreach (q[i]) begin
            p = PIX_W'($urandom);
            put_lane(p, q[i]);
            cyc(1, 0, 0, p);
        end
        c = ref_crc(q);
        if (!good) c = c ^ 32'h1;
        for (int k = 0; k < 8; k++) begin
            p = PIX_W'($urandom);
            if (k < 4) put_lane(p, c[31 - 8*k -: 8]);
            if (k == 4) put_lane(p, fid);
            cyc(0, (k == 1 || k == 2), 0, p);
        end
    endtask

    task automatic send_line(int n, bit good, logic [7:0] fid);
        byte unsigned q[$];
        for (int i = 0; i < n; i++) q.push_back(8'($urandom));
        send_q(q, good, fid);
    endtask

    task automatic new_frame();
        cyc(0, 0, 1, PIX_W'($urandom));
        cyc(0, 0, 1, PIX_W'($urandom));
        cyc(0, 0, 0, PIX_W'($urandom));
        cyc(0, 0, 0, PIX_W'($urandom));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        byte unsigned digits[$];
        rst = 1; de_i = 0; hs_i = 0; vs_i = 0; pix_i = '0; byte_sel = 2'd0; err_thresh = 8'd2;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0);
        // R11: outputs cleared during reset
        check("R11 reset outputs", {pix_o[7:0], de_o, hs_o, vs_o, line_err_o, frame_err_o,
               fid_jump_o, last_fid_o}, '0);
        check("R11 reset crc", last_crc_o, '0);
        rst = 0;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, PIX_W'($urandom));

        // frame with id 10, threshold 2
        new_frame();
        send_line(12, 1, 8'd10);
        for (int i = 0; i < 9; i++) digits.push_back(8'(8'h31 + i));
        send_q(digits, 1, 8'd99);
        check("R1 known string no mismatch", 32'(line_err_o), 0);
        check("R1 known string crc", last_crc_o, 32'h4FD9_4EA8);
        send_line(1, 1, 8'd99);          // one-pixel line, R1 restart
        check("R1 single byte line", 32'(line_err_o), 0);
        send_line(6, 0, 8'd99);
        check("R5 bad line seen", 32'(line_err_o), 1);
        check("R7 below threshold", 32'(frame_err_o), 0);
        send_line(5, 0, 8'd99);
        check("R7 threshold reached", 32'(frame_err_o), 1);
        send_line(5, 0, 8'd99);
        send_line(5, 1, 8'd99);
        check("R7 sticky", 32'(frame_err_o), 1);
        check("R9 first id kept", 32'(last_fid_o), 10);

        // next frame id 11
        new_frame();
        check("R6 cleared at frame start", 32'(frame_err_o), 0);
        send_line(8, 0, 8'd11);
        send_line(8, 1, 8'd11);
        check("R6 count restarted", 32'(frame_err_o), 0);
        check("R10 in sequence", 32'(fid_jump_o), 0);

        // skipped id 13
        new_frame();
        send_line(7, 1, 8'd13);
        check("R10 jump seen", 32'(fid_jump_o), 1);
        check("R9 id captured", 32'(last_fid_o), 13);

        // threshold 0
        err_thresh = 8'd0;
        new_frame();
        for (int i = 0; i < 4; i++) send_line(4, 0, 8'd14);
        check("R8 zero threshold", 32'(frame_err_o), 0);
        check("R10 back in sequence", 32'(fid_jump_o), 0);

        // lane 2, threshold 1
        err_thresh = 8'd1;
        byte_sel = 2'd2;
        new_frame();
        send_line(10, 1, 8'd15);
        check("R2 lane 2 good line", 32'(line_err_o), 0);
        check("R2 lane 2 id", 32'(last_fid_o), 15);
        send_line(3, 0, 8'd15);
        check("R7 threshold one", 32'(frame_err_o), 1);

        // lane 1, wrap of id 255 -> 0
        byte_sel = 2'd1;
        new_frame();
        send_line(6, 1, 8'd255);
        new_frame();
        send_line(6, 1, 8'd0);
        check("R10 modulo wrap", 32'(fid_jump_o), 0);
        check("R2 lane 1 good line", 32'(line_err_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule